// File: doc/BRIEF.md
# Program Trace Status Encoder

This block gives an external trace tool one status report per clock cycle on how the program flows. Each cycle a simple core model presents at most one completed instruction. The core model gives the instruction's branch kind, a flag for sequential instructions that change machine context, the debug-mode level, the VSYNC level and the next fetch address. The block turns these into a 3-bit flow code and a 2-bit load/flush code. A trace-attribute strobe marks the cycles whose fetch address the tool must capture, and the block presents that address next to the strobe.

Flow changes that software cannot rebuild from the program image carry the strobe and the target address. These are indirect branches and the context-changing sequential instructions: return from interrupt, machine-state writes, instruction synchronisation and writes to debug or compare control registers. While the core is in debug mode the block reports a fixed debug status. The first report after debug mode tells the tool whether VSYNC moved while the core was halted. That report also carries the address of the first fetch after the halt.

All outputs are registered. Inputs sampled at a rising edge appear on the outputs just after that edge.

Top module: `trace_status_enc`

## Requirements
- R1: While reset is asserted, flow_st is 000, lf_st is 00 and tr_attr is 0.
- R2: For every cycle with dbg_mode high, the next report is flow_st 000 and lf_st 11 with tr_attr 0, whatever the completion inputs are.
- R3: Outside debug mode and off the exit cycle, a cycle with cmp_valid low reports flow_st 000, lf_st 00 and tr_attr 0.
- R4: A completion with cmp_special low reports lf_st 01 and tr_attr 0. Its flow_st is 001 for cmp_kind 00 (sequential) or 11 (branch not taken), and 011 for cmp_kind 01 (direct branch taken).
- R5: A completion with cmp_kind 10 (indirect branch taken) reports flow_st 101 and lf_st 01. It raises tr_attr, and tr_addr carries that cycle's nxt_addr.
- R6: A completion with cmp_special high reports flow_st 101, lf_st 01, tr_attr 1 and tr_addr equal to nxt_addr, whatever its cmp_kind is.
- R7: The exit cycle is the first cycle with dbg_mode low after a cycle with it high. If VSYNC in the exit cycle equals the level it had in the first debug cycle, the exit cycle reports flow_st 101, lf_st 00, tr_attr 1 and tr_addr equal to nxt_addr.
- R8: If VSYNC in the exit cycle differs from its level in the first debug cycle, the exit cycle reports flow_st 110 when VSYNC is now high and 111 when it is now low. The report has lf_st 00, tr_attr 1 and tr_addr equal to nxt_addr.
- R9: A completion presented in the exit cycle is not reported. The exit report of R7 or R8 takes its place.
- R10: tr_attr is a one-cycle strobe. It drops in the report after any cycle that has no indirect branch, no special instruction and no debug exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | An instruction completes this cycle |
| cmp_kind | input | 2 | 00 sequential, 01 direct taken, 10 indirect taken, 11 not taken |
| cmp_special | input | 1 | Completing instruction changes machine context |
| dbg_mode | input | 1 | Core is in debug mode |
| vsync | input | 1 | Trace synchronisation level from the tool |
| nxt_addr | input | AW | Address of the next instruction fetch |
| flow_st | output | 3 | Flow status code |
| lf_st | output | 2 | Load/flush status code |
| tr_attr | output | 1 | Program-trace attribute strobe |
| tr_addr | output | AW | Fetch address qualified by tr_attr |

## Verification
Two functions can meet in one cycle: the debug-exit report and the report of a completing instruction. The bench provokes this by releasing dbg_mode in the same cycle that it presents a completion. In one case that completion is an indirect branch with cmp_special set, so on its own it would produce 101 with a strobe. The scoreboard expects the VSYNC-change code 110 instead, with the strobe and that cycle's address and lf_st 00, which shows the exit report has displaced the completion. In a second case a sequential completion on an exit with unchanged VSYNC must come out as 101, not 001.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [2:0] {
    FL_IDLE = 3'b000,
    FL_SEQ  = 3'b001,
    FL_DIR  = 3'b011,
    FL_IND  = 3'b101,
    FL_VSR  = 3'b110,
    FL_VSF  = 3'b111
  } flow_e;

  typedef enum logic [1:0] {
    K_SEQ  = 2'b00,
    K_DIR  = 2'b01,
    K_IND  = 2'b10,
    K_NTK  = 2'b11
  } kind_e;

  localparam logic [1:0] LF_NONE = 2'b00;
  localparam logic [1:0] LF_DONE = 2'b01;
  localparam logic [1:0] LF_DBG  = 2'b11;
endpackage

// File: rtl/trc_dbg_track.sv
module trc_dbg_track (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_mode,
  input  logic vsync,
  output logic dbg_q,
  output logic exit_evt,
  output logic vs_moved
);
  logic dbg_d;
  logic vs_ent_q, vs_ent_d;
  logic entry_evt;

  always_comb begin
    entry_evt = dbg_mode & ~dbg_q;
    exit_evt  = ~dbg_mode & dbg_q;
    dbg_d     = dbg_mode;
    vs_ent_d  = entry_evt ? vsync : vs_ent_q;
    vs_moved  = vsync ^ vs_ent_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q    <= 1'b0;
      vs_ent_q <= 1'b0;
    end else begin
      dbg_q    <= dbg_d;
      vs_ent_q <= vs_ent_d;
    end
  end

  // The sampled level stays fixed for the whole halt.
  AST_VS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_mode && dbg_q) |=> $stable(vs_ent_q)) else $error("AST_VS_HELD"); // R8
endmodule

// File: rtl/trc_code_sel.sv
module trc_code_sel
  import trc_pkg::*;
(
  input  logic       cmp_valid,
  input  logic [1:0] cmp_kind,
  input  logic       cmp_special,
  input  logic       dbg_mode,
  input  logic       exit_evt,
  input  logic       vs_moved,
  input  logic       vsync,
  output logic [2:0] flow_nx,
  output logic [1:0] lf_nx,
  output logic       attr_nx
);
  always_comb begin
    flow_nx = FL_IDLE;
    lf_nx   = LF_NONE;
    attr_nx = 1'b0;
    if (dbg_mode) begin
      lf_nx = LF_DBG;
    end else if (exit_evt) begin
      attr_nx = 1'b1;
      if (vs_moved) flow_nx = vsync ? FL_VSR : FL_VSF;
      else          flow_nx = FL_IND;
    end else if (cmp_valid) begin
      lf_nx = LF_DONE;
      if (cmp_special || cmp_kind == K_IND) begin
        flow_nx = FL_IND;
        attr_nx = 1'b1;
      end else if (cmp_kind == K_DIR) begin
        flow_nx = FL_DIR;
      end else begin
        flow_nx = FL_SEQ;
      end
    end
  end
endmodule

// File: rtl/trc_out_reg.sv
module trc_out_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    flow_nx,
  input  logic [1:0]    lf_nx,
  input  logic          attr_nx,
  input  logic [AW-1:0] addr_in,
  output logic [2:0]    flow_q,
  output logic [1:0]    lf_q,
  output logic          attr_q,
  output logic [AW-1:0] addr_q
);
  logic          addr_en;
  logic [AW-1:0] addr_d;

  always_comb begin
    addr_en = attr_nx;
    addr_d  = addr_en ? addr_in : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_q <= 3'b000;
      lf_q   <= 2'b00;
      attr_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flow_q <= flow_nx;
      lf_q   <= lf_nx;
      attr_q <= attr_nx;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/trace_status_enc.sv
module trace_status_enc
  import trc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  logic [1:0]    cmp_kind,
  input  logic          cmp_special,
  input  logic          dbg_mode,
  input  logic          vsync,
  input  logic [AW-1:0] nxt_addr,
  output logic [2:0]    flow_st,
  output logic [1:0]    lf_st,
  output logic          tr_attr,
  output logic [AW-1:0] tr_addr
);
  logic       dbg_q, exit_evt, vs_moved;
  logic [2:0] flow_nx;
  logic [1:0] lf_nx;
  logic       attr_nx;

  trc_dbg_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbg_mode (dbg_mode),
    .vsync    (vsync),
    .dbg_q    (dbg_q),
    .exit_evt (exit_evt),
    .vs_moved (vs_moved)
  );

  trc_code_sel u_sel (
    .cmp_valid   (cmp_valid),
    .cmp_kind    (cmp_kind),
    .cmp_special (cmp_special),
    .dbg_mode    (dbg_mode),
    .exit_evt    (exit_evt),
    .vs_moved    (vs_moved),
    .vsync       (vsync),
    .flow_nx     (flow_nx),
    .lf_nx       (lf_nx),
    .attr_nx     (attr_nx)
  );

  trc_out_reg #(.AW(AW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .flow_nx (flow_nx),
    .lf_nx   (lf_nx),
    .attr_nx (attr_nx),
    .addr_in (nxt_addr),
    .flow_q  (flow_st),
    .lf_q    (lf_st),
    .attr_q  (tr_attr),
    .addr_q  (tr_addr)
  );

  AST_DBG_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> (flow_st == 3'b000 && lf_st == 2'b11 && !tr_attr)) else $error("AST_DBG_STATUS"); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_valid && !dbg_mode && !dbg_q) |=> (flow_st == 3'b000 && lf_st == 2'b00)) else $error("AST_IDLE_QUIET"); // R3
  AST_SPECIAL_IND: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && cmp_special && !dbg_mode && !dbg_q) |=> (flow_st == 3'b101 && tr_attr)) else $error("AST_SPECIAL_IND"); // R6
  AST_EXIT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_q && !dbg_mode) |=> (tr_attr && flow_st[2] && lf_st == 2'b00)) else $error("AST_EXIT_MARK"); // R9
  AST_ATTR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tr_attr |-> flow_st[2] && flow_st != 3'b100) else $error("AST_ATTR_CODE"); // R10
  AST_ADDR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    tr_attr |-> tr_addr == $past(nxt_addr)) else $error("AST_ADDR_TRACK"); // R5
endmodule

// File: tb/trace_status_enc_bench.sv
module trace_status_enc_bench;
  localparam int AW = 32;

  typedef struct {
    logic [2:0]    flow;
    logic [1:0]    lf;
    logic          attr;
    logic [AW-1:0] addr;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmp_valid, cmp_special, dbg_mode, vsync;
  logic [1:0]    cmp_kind;
  logic [AW-1:0] nxt_addr;
  logic [2:0]    flow_st;
  logic [1:0]    lf_st;
  logic          tr_attr;
  logic [AW-1:0] tr_addr;

  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  trace_status_enc #(.AW(AW)) u_trace_status_enc (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
    .cmp_special(cmp_special), .dbg_mode(dbg_mode), .vsync(vsync),
    .nxt_addr(nxt_addr), .flow_st(flow_st), .lf_st(lf_st),
    .tr_attr(tr_attr), .tr_addr(tr_addr)
  );

  task automatic step(input logic v, input logic [1:0] k, input logic sp,
                      input logic dm, input logic vs, input logic [AW-1:0] a,
                      input logic [2:0] ef, input logic [1:0] el, input logic ea,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cmp_valid = v; cmp_kind = k; cmp_special = sp;
    dbg_mode = dm; vsync = vs; nxt_addr = a;
    e.flow = ef; e.lf = el; e.attr = ea; e.addr = a; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (flow_st !== e.flow || lf_st !== e.lf || tr_attr !== e.attr ||
          (e.attr && tr_addr !== e.addr)) begin
        fails++;
        $display("FAIL %s: got flow=%b lf=%b attr=%b addr=%h exp flow=%b lf=%b attr=%b addr=%h",
                 e.tag, flow_st, lf_st, tr_attr, tr_addr, e.flow, e.lf, e.attr, e.addr);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmp_valid = 0; cmp_kind = 2'b00; cmp_special = 0;
    dbg_mode = 0; vsync = 0; nxt_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (flow_st !== 3'b000 || lf_st !== 2'b00 || tr_attr !== 1'b0) begin
      fails++;
      $display("FAIL R1: got flow=%b lf=%b attr=%b exp 000 00 0", flow_st, lf_st, tr_attr);
    end
    @(negedge clk) rst_n = 1'b1;

    step(0, 2'b00, 0, 0, 0, 32'h0000_0010, 3'b000, 2'b00, 0, "R3 idle");
    step(1, 2'b00, 0, 0, 0, 32'h0000_0014, 3'b001, 2'b01, 0, "R4 sequential");
    step(1, 2'b11, 0, 0, 0, 32'h0000_0018, 3'b001, 2'b01, 0, "R4 not taken");
    step(1, 2'b01, 0, 0, 0, 32'h0000_0100, 3'b011, 2'b01, 0, "R4 direct");
    step(1, 2'b10, 0, 0, 0, 32'h0000_2000, 3'b101, 2'b01, 1, "R5 indirect");
    step(1, 2'b00, 1, 0, 0, 32'h0000_2004, 3'b101, 2'b01, 1, "R6 special seq");
    step(1, 2'b01, 1, 0, 0, 32'h0000_3000, 3'b101, 2'b01, 1, "R6 special direct");
    step(1, 2'b00, 0, 0, 0, 32'h0000_3004, 3'b001, 2'b01, 0, "R10 strobe drops");
    // halt with VSYNC toggled and restored: level unchanged
    step(1, 2'b10, 1, 1, 0, 32'h0000_4000, 3'b000, 2'b11, 0, "R2 debug entry");
    step(0, 2'b00, 0, 1, 1, 32'h0000_4004, 3'b000, 2'b11, 0, "R2 debug vsync up");
    step(0, 2'b00, 0, 1, 0, 32'h0000_4008, 3'b000, 2'b11, 0, "R2 debug vsync down");
    step(1, 2'b00, 0, 0, 0, 32'h0000_5000, 3'b101, 2'b00, 1, "R7 R9 exit unchanged");
    step(0, 2'b00, 0, 0, 0, 32'h0000_5004, 3'b000, 2'b00, 0, "R10 R3 after exit");
    // halt during which VSYNC rises; exit collides with special indirect
    step(0, 2'b00, 0, 1, 0, 32'h0000_6000, 3'b000, 2'b11, 0, "R2 debug entry low");
    step(1, 2'b01, 0, 1, 1, 32'h0000_6004, 3'b000, 2'b11, 0, "R2 debug completion");
    step(1, 2'b10, 1, 0, 1, 32'h0000_7000, 3'b110, 2'b00, 1, "R8 R9 exit vsync rose");
    // halt during which VSYNC falls
    step(0, 2'b00, 0, 1, 1, 32'h0000_8000, 3'b000, 2'b11, 0, "R2 debug entry high");
    step(0, 2'b00, 0, 0, 0, 32'h0000_9000, 3'b111, 2'b00, 1, "R8 exit vsync fell");
    step(1, 2'b01, 0, 0, 0, 32'h0000_9004, 3'b011, 2'b01, 0, "R10 R4 after exit");
    // one-cycle halt, VSYNC high throughout
    step(0, 2'b00, 0, 1, 1, 32'h0000_A000, 3'b000, 2'b11, 0, "R2 short halt");
    step(0, 2'b00, 0, 0, 1, 32'h0000_A100, 3'b101, 2'b00, 1, "R7 exit high unchanged");
    step(0, 2'b00, 0, 0, 1, 32'h0000_A104, 3'b000, 2'b00, 0, "R3 R10 idle");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule